// File: doc/BRIEF.md
# Power converter fault response controller

This block sits between the digital outputs of a multi-rail power controller's comparators and the enables of its power stages. Five fault classes reach it as synchronous levels: rail overvoltage, rail undervoltage, flyback primary overcurrent, second-level peak overcurrent and average output overcurrent. A sixth input vector carries first-level cycle-by-cycle current-limit events, one bit per phase. Every event latches a sticky status bit and pulls the active-low alert output low. The alert stays low until software clears every status bit.

Each protective fault class resolves to hiccup, latch-off or ignore. By default a mode pin makes that choice for all classes. When a global override bit is set, each class uses its own 2-bit field instead. Supply-side faults turn off the main controller, the flyback converter, the internal regulators and the MCU regulator, and they restart from full initialization. Main-path current faults turn off only the main controller and restart it from soft-start. In hiccup the restart comes after a counted interval, 500 ms by default. In latch-off the restart waits for an enable toggle. A small register port gives access to configuration and status.

Top module: `pwr_fault_resp`

## Requirements
- R1: A high level on any fault input sets its status bit at the next clock edge and drives `alert_no` low. Status bit positions: 0 rail overvoltage, 1 rail undervoltage, 2 flyback overcurrent, 3 second-level peak overcurrent, 4 average overcurrent, 5 cycle-by-cycle limit.
- R2: Status bits are sticky. Writing 1 to a bit at address 3 clears it, and a fault present in the same cycle wins over the clear. `alert_no` returns high only when all six bits are clear.
- R3: When the override bit (address 0 bit 0) is 0, `resp_mode_i` selects the response for all classes (0 hiccup, 1 latch-off). When it is 1, each class uses its own field: 00 follows `resp_mode_i`, 01 hiccup, 10 latch-off, 11 status only with no shutdown.
- R4: A rail overvoltage, rail undervoltage or flyback overcurrent fault with an active response drops all four enable outputs one cycle later.
- R5: A second-level peak or average overcurrent fault with an active response drops only `main_en_o`. The flyback and both regulator enables stay high.
- R6: Hiccup keeps the outputs off for exactly `CLK_KHZ*HICCUP_MS` cycles, then restores them. The restore pulses `init_start_o` for a supply-side fault and `ss_start_o` for a main-path fault.
- R7: Latch-off after a supply-side fault keeps all enables low until an `en_i` toggle. The toggle restores them and pulses `init_start_o`.
- R8: Latch-off after a main-path fault has two exits. An `en_pwm_i` toggle restores `main_en_o` and pulses `ss_start_o`. An `en_i` toggle first drops the flyback and regulator enables for at least one cycle, then restores everything and pulses `init_start_o`.
- R9: A toggle is a falling edge followed by a rising edge, both seen while waiting in latch-off. A level held high never restarts. An `en_pwm_i` toggle has no effect on a supply-side latch-off.
- R10: A cycle-by-cycle limit event sets status bit 5 and the matching bit of the phase register (address 4, W1C). It drives the alert low and leaves all enables high.
- R11: If supply-side and main-path faults arrive together, the full shutdown wins. A supply-side fault during a main-path shutdown escalates to a full shutdown.
- R12: Register map: address 0 bit 0 is the override bit. Address 1 holds the fields for overvoltage [1:0], undervoltage [3:2], flyback [5:4] and second-level peak [7:6]. Address 2 [1:0] holds the average-overcurrent field. All of these read back what was written, and unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| resp_mode_i | input | 1 | Default response: 0 hiccup, 1 latch-off |
| en_i | input | 1 | Main enable, toggled to restart from initialization |
| en_pwm_i | input | 1 | PWM enable, toggled to restart the main controller |
| rail_ov_i | input | 1 | Rail overvoltage fault |
| rail_uv_i | input | 1 | Rail undervoltage fault |
| fly_oc_i | input | 1 | Flyback primary overcurrent fault |
| oc2_i | input | 1 | Second-level peak overcurrent fault |
| acp_i | input | 1 | Average output overcurrent fault |
| oc1_phase_i | input | NUM_PHASES | Cycle-by-cycle limit event per phase |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| alert_no | output | 1 | Alert, low while any status bit is set |
| main_en_o | output | 1 | Main controller enable |
| fly_en_o | output | 1 | Flyback controller enable |
| ldo_en_o | output | 1 | Internal regulator enable |
| mcu_ldo_en_o | output | 1 | MCU regulator enable |
| init_start_o | output | 1 | One-cycle pulse: restart from initialization |
| ss_start_o | output | 1 | One-cycle pulse: restart from soft-start |

## Verification
Directed sequences drive each fault class under hiccup and under latch-off. They separate a full teardown from a main-only stop, and an initialization restart from a soft-start restart. Latch-off is probed with a held-high enable, with the wrong enable toggled and with the right one toggled, so that a real toggle is told apart from a level and the two exits of a main-path latch are distinguished. Simultaneous and escalating faults show which fault class takes priority. A seeded random phase sets every field to status-only. It then fires random fault and phase patterns mixed with random write-one-to-clear masks, which separates set-over-clear ordering and alert release from any shutdown side effect.

// File: rtl/pfr_pkg.sv
package pfr_pkg;
  localparam int NCLS  = 5;          // protective fault classes
  localparam int NSTAT = NCLS + 1;   // plus cycle-by-cycle limit
  localparam int DW    = 8;

  // class index: 0 ov, 1 uv, 2 flyback (full scope), 3 oc2, 4 acp (main only)
  localparam int NFULL = 3;

  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_RSP0  = 3'd1;
  localparam logic [2:0] A_RSP1  = 3'd2;
  localparam logic [2:0] A_STAT  = 3'd3;
  localparam logic [2:0] A_PHASE = 3'd4;

  typedef enum logic [2:0] {
    ST_RUN, ST_HIC_FULL, ST_LAT_FULL, ST_HIC_MAIN, ST_LAT_MAIN, ST_DROP
  } seq_st_e;

  typedef enum logic [1:0] {ACT_NONE, ACT_HIC, ACT_LAT} act_e;

  function automatic act_e resolve(input logic indiv, input logic [1:0] fld,
                                   input logic mode_lat);
    if (!indiv || fld == 2'b00) return mode_lat ? ACT_LAT : ACT_HIC;
    case (fld)
      2'b01:   return ACT_HIC;
      2'b10:   return ACT_LAT;
      default: return ACT_NONE;
    endcase
  endfunction
endpackage

// File: rtl/pfr_regs.sv
module pfr_regs
  import pfr_pkg::*;
#(
  parameter int NUM_PHASES = 4   // 1..8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [2:0]            addr_i,
  input  logic [DW-1:0]         wdata_i,
  input  logic [NCLS-1:0]       flt_i,
  input  logic [NUM_PHASES-1:0] oc1_i,
  output logic [DW-1:0]         rdata_o,
  output logic                  indiv_o,
  output logic [NCLS-1:0][1:0]  fld_o,
  output logic                  alert_no_o
);
  logic                  indiv_q;
  logic [NCLS-1:0][1:0]  rsp_q;
  logic [NSTAT-1:0]      stat_q, stat_clr, stat_set;
  logic [NUM_PHASES-1:0] ph_q, ph_clr;
  logic wr_ctrl, wr_rsp0, wr_rsp1, wr_stat, wr_ph;

  assign wr_ctrl = we_i && addr_i == A_CTRL;
  assign wr_rsp0 = we_i && addr_i == A_RSP0;
  assign wr_rsp1 = we_i && addr_i == A_RSP1;
  assign wr_stat = we_i && addr_i == A_STAT;
  assign wr_ph   = we_i && addr_i == A_PHASE;

  assign stat_clr = wr_stat ? wdata_i[NSTAT-1:0] : '0;
  assign ph_clr   = wr_ph ? wdata_i[NUM_PHASES-1:0] : '0;
  assign stat_set = {|oc1_i, flt_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      indiv_q <= 1'b0;
      rsp_q   <= '0;
      stat_q  <= '0;
      ph_q    <= '0;
    end else begin
      if (wr_ctrl) indiv_q <= wdata_i[0];
      if (wr_rsp0) rsp_q[3:0] <= wdata_i;
      if (wr_rsp1) rsp_q[4] <= wdata_i[1:0];
      // set wins over clear
      stat_q <= (stat_q & ~stat_clr) | stat_set;
      ph_q   <= (ph_q & ~ph_clr) | oc1_i;
    end
  end

  always_comb begin
    case (addr_i)
      A_CTRL:  rdata_o = {7'd0, indiv_q};
      A_RSP0:  rdata_o = rsp_q[3:0];
      A_RSP1:  rdata_o = {6'd0, rsp_q[4]};
      A_STAT:  rdata_o = DW'(stat_q);
      A_PHASE: rdata_o = DW'(ph_q);
      default: rdata_o = '0;
    endcase
  end

  assign indiv_o    = indiv_q;
  assign fld_o      = rsp_q;
  assign alert_no_o = ~|stat_q;

  p_fault_alert_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|stat_set) |=> !alert_no_o);
  p_w1c_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat && wdata_i[0] && !flt_i[0]) |=> !stat_q[0]);
  p_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q[3] && !(wr_stat && wdata_i[3])) |=> stat_q[3]);
endmodule

// File: rtl/pfr_toggle.sv
module pfr_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic clr_i,
  output logic tog_o
);
  logic [2:0] sh_q;
  logic       armed_q, fall, rise;

  assign fall = sh_q[2] & ~sh_q[1];
  assign rise = ~sh_q[2] & sh_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= 3'b111;
      armed_q <= 1'b0;
    end else begin
      sh_q <= {sh_q[1:0], lvl_i};
      if (clr_i)     armed_q <= 1'b0;
      else if (fall) armed_q <= 1'b1;
      else if (rise) armed_q <= 1'b0;
    end
  end

  assign tog_o = armed_q & rise & ~clr_i;
endmodule

// File: rtl/pfr_seq.sv
module pfr_seq
  import pfr_pkg::*;
#(
  parameter int HIC_CYC = 25_000_000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NCLS-1:0] hic_req_i,
  input  logic [NCLS-1:0] lat_req_i,
  input  logic            tog_en_i,
  input  logic            tog_pwm_i,
  output logic            clr_en_o,
  output logic            clr_pwm_o,
  output logic            main_en_o,
  output logic            fly_en_o,
  output logic            ldo_en_o,
  output logic            mcu_ldo_en_o,
  output logic            init_start_o,
  output logic            ss_start_o
);
  localparam int CW = $clog2(HIC_CYC) + 1;
  localparam logic [CW-1:0] LAST = CW'(HIC_CYC - 1);

  seq_st_e st_q, st_d;
  logic [CW-1:0] cnt_q;
  logic full_lat, full_hic, main_lat, main_hic, full_any, main_any, cnt_last;
  logic init_d, ss_d, init_q, ss_q, in_hic;

  assign full_lat = |lat_req_i[NFULL-1:0];
  assign full_hic = |hic_req_i[NFULL-1:0];
  assign main_lat = |lat_req_i[NCLS-1:NFULL];
  assign main_hic = |hic_req_i[NCLS-1:NFULL];
  assign full_any = full_lat | full_hic;
  assign main_any = main_lat | main_hic;
  assign cnt_last = cnt_q == LAST;
  assign in_hic   = st_q == ST_HIC_FULL || st_q == ST_HIC_MAIN;

  always_comb begin
    st_d   = st_q;
    init_d = 1'b0;
    ss_d   = 1'b0;
    case (st_q)
      ST_RUN: begin
        if (full_lat)      st_d = ST_LAT_FULL;
        else if (full_hic) st_d = ST_HIC_FULL;
        else if (main_lat) st_d = ST_LAT_MAIN;
        else if (main_hic) st_d = ST_HIC_MAIN;
      end
      ST_HIC_MAIN, ST_LAT_MAIN: begin
        if (full_lat)      st_d = ST_LAT_FULL;
        else if (full_hic) st_d = ST_HIC_FULL;
        else if (st_q == ST_HIC_MAIN) begin
          if (cnt_last) begin st_d = ST_RUN; ss_d = 1'b1; end
        end else if (tog_en_i) st_d = ST_DROP;
        else if (tog_pwm_i) begin st_d = ST_RUN; ss_d = 1'b1; end
      end
      ST_HIC_FULL: if (cnt_last) begin st_d = ST_RUN; init_d = 1'b1; end
      ST_LAT_FULL: if (tog_en_i) begin st_d = ST_RUN; init_d = 1'b1; end
      ST_DROP:     begin st_d = ST_RUN; init_d = 1'b1; end
      default:     st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_RUN;
      cnt_q  <= '0;
      init_q <= 1'b0;
      ss_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= (st_d != st_q || !in_hic) ? '0 : cnt_q + 1'b1;
      init_q <= init_d;
      ss_q   <= ss_d;
    end
  end

  assign main_en_o    = st_q == ST_RUN;
  assign fly_en_o     = st_q == ST_RUN || st_q == ST_HIC_MAIN || st_q == ST_LAT_MAIN;
  assign ldo_en_o     = fly_en_o;
  assign mcu_ldo_en_o = fly_en_o;
  assign init_start_o = init_q;
  assign ss_start_o   = ss_q;
  assign clr_en_o     = !(st_q == ST_LAT_FULL || st_q == ST_LAT_MAIN);
  assign clr_pwm_o    = st_q != ST_LAT_MAIN;

  p_full_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_RUN || st_q == ST_HIC_MAIN || st_q == ST_LAT_MAIN) && full_any)
    |=> (!main_en_o && !fly_en_o && !ldo_en_o && !mcu_ldo_en_o));
  p_main_only_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && !full_any && main_any)
    |=> (!main_en_o && fly_en_o && ldo_en_o && mcu_ldo_en_o));
  p_hic_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HIC_FULL && !cnt_last) |=> !mcu_ldo_en_o);
  p_latch_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LAT_FULL && !tog_en_i) |=> (!mcu_ldo_en_o && !init_start_o));
  p_drop_first_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LAT_MAIN && tog_en_i) |=> !fly_en_o);
  p_one_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(init_start_o && ss_start_o));
endmodule

// File: rtl/pwr_fault_resp.sv
module pwr_fault_resp
  import pfr_pkg::*;
#(
  parameter int NUM_PHASES = 4,
  parameter int CLK_KHZ    = 50_000,
  parameter int HICCUP_MS  = 500
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  resp_mode_i,
  input  logic                  en_i,
  input  logic                  en_pwm_i,
  input  logic                  rail_ov_i,
  input  logic                  rail_uv_i,
  input  logic                  fly_oc_i,
  input  logic                  oc2_i,
  input  logic                  acp_i,
  input  logic [NUM_PHASES-1:0] oc1_phase_i,
  input  logic                  reg_we_i,
  input  logic [2:0]            reg_addr_i,
  input  logic [7:0]            reg_wdata_i,
  output logic [7:0]            reg_rdata_o,
  output logic                  alert_no,
  output logic                  main_en_o,
  output logic                  fly_en_o,
  output logic                  ldo_en_o,
  output logic                  mcu_ldo_en_o,
  output logic                  init_start_o,
  output logic                  ss_start_o
);
  localparam int HIC_CYC = CLK_KHZ * HICCUP_MS;

  logic [NCLS-1:0]      flt, hic_req, lat_req;
  logic [NCLS-1:0][1:0] fld;
  logic indiv, tog_en, tog_pwm, clr_en, clr_pwm;

  assign flt = {acp_i, oc2_i, fly_oc_i, rail_uv_i, rail_ov_i};

  pfr_regs #(.NUM_PHASES(NUM_PHASES)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .flt_i(flt), .oc1_i(oc1_phase_i),
    .rdata_o(reg_rdata_o), .indiv_o(indiv), .fld_o(fld), .alert_no_o(alert_no)
  );

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    act_e act;
    assign act        = resolve(indiv, fld[c], resp_mode_i);
    assign hic_req[c] = flt[c] && act == ACT_HIC;
    assign lat_req[c] = flt[c] && act == ACT_LAT;
  end

  pfr_toggle u_tog_en  (.clk_i, .rst_ni, .lvl_i(en_i),     .clr_i(clr_en),  .tog_o(tog_en));
  pfr_toggle u_tog_pwm (.clk_i, .rst_ni, .lvl_i(en_pwm_i), .clr_i(clr_pwm), .tog_o(tog_pwm));

  pfr_seq #(.HIC_CYC(HIC_CYC)) u_seq (
    .clk_i, .rst_ni,
    .hic_req_i(hic_req), .lat_req_i(lat_req),
    .tog_en_i(tog_en), .tog_pwm_i(tog_pwm),
    .clr_en_o(clr_en), .clr_pwm_o(clr_pwm),
    .main_en_o, .fly_en_o, .ldo_en_o, .mcu_ldo_en_o,
    .init_start_o, .ss_start_o
  );
endmodule

// File: tb/pwr_fault_resp_test.sv
module pwr_fault_resp_test;
  localparam int CLK_PERIOD = 10;
  localparam int NP  = 4;
  localparam int HIC = 20;  // CLK_KHZ 4 * HICCUP_MS 5

  logic clk = 0, rst_n = 0;
  logic mode = 0, en = 1, en_pwm = 1;
  logic ov = 0, uv = 0, fly = 0, oc2 = 0, acp = 0;
  logic [NP-1:0] oc1 = '0;
  logic we = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic alert_n, main_en, fly_en, ldo_en, mcu_en, init_p, ss_p;

  int n_chk = 0, n_bad = 0;
  int n_init = 0, n_ss = 0, n_fly_low = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_fault_resp #(.NUM_PHASES(NP), .CLK_KHZ(4), .HICCUP_MS(5)) uut (
    .clk_i(clk), .rst_ni(rst_n), .resp_mode_i(mode), .en_i(en), .en_pwm_i(en_pwm),
    .rail_ov_i(ov), .rail_uv_i(uv), .fly_oc_i(fly), .oc2_i(oc2), .acp_i(acp),
    .oc1_phase_i(oc1), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .alert_no(alert_n), .main_en_o(main_en), .fly_en_o(fly_en),
    .ldo_en_o(ldo_en), .mcu_ldo_en_o(mcu_en), .init_start_o(init_p), .ss_start_o(ss_p)
  );

  always @(negedge clk) begin
    if (init_p) n_init++;
    if (ss_p) n_ss++;
    if (!fly_en) n_fly_low++;
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] en_exp(bit main_on, bit aux_on);
    return {main_on, aux_on, aux_on, aux_on};
  endfunction

  function automatic logic [3:0] ens();
    return {main_en, fly_en, ldo_en, mcu_en};
  endfunction

  task automatic wr(logic [2:0] a, logic [7:0] d);
    we = 1; addr = a; wdata = d;
    tick(1);
    we = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic toggle_en();
    en = 0; tick(4); en = 1; tick(6);
  endtask

  task automatic toggle_pwm();
    en_pwm = 0; tick(4); en_pwm = 1; tick(6);
  endtask

  task automatic clear_all();
    wr(3'd3, 8'h3F); wr(3'd4, 8'hFF);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int i0, i1, f0, s0;
    logic [5:0] model;
    void'($urandom(32'h5EED_1234));
    tick(3); rst_n = 1; tick(2);

    // reset state
    chk("R2 reset enables", ens(), 4'hF);
    chk("R2 reset alert", alert_n, 1);
    rd(3'd3, d); chk("R2 reset status", d, 0);

    // R12 register map
    wr(3'd1, 8'hA5); rd(3'd1, d); chk("R12 rsp0", d, 8'hA5);
    wr(3'd2, 8'hFF); rd(3'd2, d); chk("R12 rsp1", d, 8'h03);
    wr(3'd0, 8'hFF); rd(3'd0, d); chk("R12 ctrl", d, 8'h01);
    rd(3'd6, d); chk("R12 unused addr", d, 0);
    wr(3'd0, 0); wr(3'd1, 0); wr(3'd2, 0);

    // R10 cycle-by-cycle limit
    oc1 = 4'b0100; tick(1); oc1 = 0;
    rd(3'd3, d); chk("R10 status bit5", d, 8'h20);
    rd(3'd4, d); chk("R10 phase", d, 8'h04);
    chk("R10 alert", alert_n, 0);
    tick(3); chk("R10 no shutdown", ens(), 4'hF);
    wr(3'd4, 8'h04); rd(3'd4, d); chk("R10 phase W1C", d, 0);
    chk("R2 alert held by bit5", alert_n, 0);
    wr(3'd3, 8'h20); chk("R2 alert released", alert_n, 1);

    // R4/R6 hiccup on rail overvoltage
    mode = 0; i0 = n_init;
    ov = 1; tick(1); ov = 0;
    chk("R4 all off", ens(), 4'h0);
    chk("R1 alert", alert_n, 0);
    rd(3'd3, d); chk("R1 status bit0", d, 8'h01);
    tick(HIC - 2); chk("R6 still off", ens(), 4'h0);
    tick(4); chk("R6 restored", ens(), 4'hF);
    chk("R6 init pulse", n_init - i0, 1);
    clear_all();

    // R5/R6 hiccup on oc2
    s0 = n_ss; i0 = n_init;
    oc2 = 1; tick(1); oc2 = 0;
    chk("R5 main only", ens(), en_exp(0, 1));
    tick(HIC - 2); chk("R6 main still off", ens(), en_exp(0, 1));
    tick(4); chk("R6 main restored", ens(), 4'hF);
    chk("R6 ss pulse", n_ss - s0, 1);
    chk("R6 no init pulse", n_init - i0, 0);
    clear_all();

    // R7/R9 latch-off on flyback
    mode = 1; i0 = n_init;
    fly = 1; tick(1); fly = 0;
    chk("R7 all off", ens(), 4'h0);
    tick(HIC + 10); chk("R9 level held high", ens(), 4'h0);
    toggle_pwm(); chk("R9 pwm toggle ignored", ens(), 4'h0);
    toggle_en(); chk("R7 restored", ens(), 4'hF);
    chk("R7 init pulse", n_init - i0, 1);
    clear_all();

    // R8 latch-off on acp, pwm exit
    s0 = n_ss; f0 = n_fly_low;
    acp = 1; tick(1); acp = 0;
    chk("R5 acp main only", ens(), en_exp(0, 1));
    toggle_pwm();
    chk("R8 pwm restart", ens(), 4'hF);
    chk("R8 ss pulse", n_ss - s0, 1);
    chk("R8 flyback kept", n_fly_low - f0, 0);
    clear_all();

    // R8 latch-off on oc2, main-enable exit
    i0 = n_init; f0 = n_fly_low;
    oc2 = 1; tick(1); oc2 = 0;
    toggle_en();
    chk("R8 en restart", ens(), 4'hF);
    chk("R8 init pulse", n_init - i0, 1);
    chk("R8 brief drop", (n_fly_low - f0) > 0, 1);
    clear_all();

    // R3 per-class fields: ov=01 uv=10 fly=11 oc2=00
    wr(3'd0, 8'h01); wr(3'd1, 8'h39);
    mode = 1;
    ov = 1; tick(1); ov = 0;
    tick(HIC + 3); chk("R3 field hiccup over mode", ens(), 4'hF);
    mode = 0;
    uv = 1; tick(1); uv = 0;
    tick(HIC + 5); chk("R3 field latch over mode", ens(), 4'h0);
    toggle_en(); chk("R3 latch released", ens(), 4'hF);
    fly = 1; tick(1); fly = 0; tick(2);
    chk("R3 ignore keeps enables", ens(), 4'hF);
    rd(3'd3, d); chk("R3 ignore sets status", d[2], 1);
    mode = 1;
    oc2 = 1; tick(1); oc2 = 0;
    tick(HIC + 5); chk("R3 field 00 follows mode", ens(), en_exp(0, 1));
    toggle_pwm(); chk("R3 pwm exit", ens(), 4'hF);
    wr(3'd0, 0); wr(3'd1, 0);
    clear_all();

    // R11 priority
    mode = 0; i0 = n_init; s0 = n_ss;
    oc2 = 1; uv = 1; tick(1); oc2 = 0; uv = 0;
    chk("R11 full wins", ens(), 4'h0);
    tick(HIC + 3);
    chk("R11 init restart", n_init - i0, 1);
    chk("R11 no ss restart", n_ss - s0, 0);
    mode = 1;
    acp = 1; tick(1); acp = 0;
    chk("R11 main latch", ens(), en_exp(0, 1));
    ov = 1; tick(1); ov = 0;
    chk("R11 escalate", ens(), 4'h0);
    toggle_pwm(); chk("R11 pwm no exit", ens(), 4'h0);
    toggle_en(); chk("R11 en exit", ens(), 4'hF);
    clear_all();

    // random: status-only responses, random faults and W1C masks
    wr(3'd0, 8'h01); wr(3'd1, 8'hFF); wr(3'd2, 8'h03);
    model = 0;
    for (int k = 0; k < 300; k++) begin
      logic [4:0] f;
      logic [NP-1:0] p;
      logic [5:0] m;
      bit w;
      f = ($urandom % 4 == 0) ? 5'($urandom) : 5'd0;
      p = ($urandom % 5 == 0) ? NP'($urandom) : '0;
      w = ($urandom % 2) == 1;
      m = 6'($urandom);
      {acp, oc2, fly, uv, ov} = f; oc1 = p;
      if (w) begin we = 1; addr = 3'd3; wdata = {2'b00, m}; end
      tick(1);
      we = 0; {acp, oc2, fly, uv, ov} = 0; oc1 = 0;
      model = (model & ~(w ? m : 6'd0)) | {|p, f};
      rd(3'd3, d);
      chk("R2 random status", d, {2'b00, model});
      chk("R1 random alert", alert_n, model == 0);
      chk("R3 random ignore", ens(), 4'hF);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule